// File: doc/BRIEF.md
# Flash DMA Engine

The block moves a run of bytes between the serial flash data path and system memory once software has already issued the command and address phases to the flash device. Software programs a memory byte address and a byte count, optionally sets a lane-width code for the flash side, and then writes a direction code to a start register. The engine then works through the run one byte at a time on the flash side and one 32-bit word at a time on the memory side. When the run is finished it sets a sticky pending flag, which can raise an interrupt.

On the flash side the engine talks to the shared lane-width shifter through a byte request/acknowledge pair. The shifter receives the lane code unchanged. On the memory side it uses a word request port with byte enables. Each request is held until it is acknowledged. Runs longer than the per-direction limit are cut to that limit. Splitting long runs into pieces is left to software.

Top module: `flash_dma_engine`

## Requirements
- R1: After reset the pending flag, the interrupt, all status busy bits and both request outputs are 0.
- R2: Register byte offsets are: configuration 0x00, start 0x18, memory address 0x1c, pending 0x20 (bit 0), length 0x24 (byte count in bits 15:0, lane code in bits 29:28) and status 0x40. The address, length and configuration registers read back what was written.
- R3: Start value bit 0 = 0 begins a flash-to-memory run. Flash byte i is written to memory byte address base+i. The byte at word offset k sits in data bits 31-8k down to 24-8k, and enable bit 3-k marks it. Bytes outside the run are never enabled.
- R4: Start value bit 0 = 1 begins a memory-to-flash run. Whole words are read, and the bytes at base, base+1, and so on are sent to the flash in address order, starting from any byte offset.
- R5: When a run ends, the pending flag is set in the same cycle that the busy bits clear. Writing 1 to pending bit 0 clears it. Writing 0 leaves it unchanged.
- R6: The interrupt output is 1 exactly when configuration bit 20 is 1 and the pending flag is set.
- R7: While a run is active, status bit 3 is 1. Bit 2 is also 1 for a flash-to-memory run, and bit 1 is also 1 for a memory-to-flash run.
- R8: A count above 2080 on a flash-to-memory run is cut to 2080 bytes. A count above 520 on a memory-to-flash run is cut to 520 bytes.
- R9: A count of 0 sets the pending flag on the next clock and issues no memory or flash request.
- R10: While a run is active, writes to the address, length and start registers are ignored. The configuration register stays writable.
- R11: A memory or flash request, once raised, is held with stable contents until it is acknowledged. The two are never raised together, and the flash lane code output equals the lane code in the length register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| fl_req | output | 1 | Flash byte request |
| fl_wr | output | 1 | Flash byte is outbound to the device |
| fl_width | output | 2 | Lane code for the shifter |
| fl_wbyte | output | 8 | Byte to the flash |
| fl_rbyte | input | 8 | Byte from the flash |
| fl_ack | input | 1 | Flash byte acknowledge |

## Verification
If the byte pointer or the lane index drifts, the error appears at the memory port on the very next word write. It shows up as a byte enabled outside the run or as a byte in the wrong lane. If the remaining count goes wrong, the run ends early or late, which appears as a wrong byte total once busy drops. A fault in the completion logic shows up on the first poll after the run, as a pending flag or busy bit that disagrees with the other.

// File: rtl/flash_dma_engine.sv
module flash_dma_engine #(
  parameter int RD_MAX = 2080,
  parameter int WR_MAX = 520,
  parameter int IE_BIT = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        fl_req,
  output logic        fl_wr,
  output logic [1:0]  fl_width,
  output logic [7:0]  fl_wbyte,
  input  logic [7:0]  fl_rbyte,
  input  logic        fl_ack
);
  localparam logic [15:0] RD_LIM = 16'(RD_MAX);
  localparam logic [15:0] WR_LIM = 16'(WR_MAX);

  typedef enum logic [2:0] {S_IDLE, S_FGET, S_MPUT, S_MGET, S_FPUT} st_t;
  st_t st;

  logic [31:0] cfg, base, ptr, buffer;
  logic [15:0] cnt, left;
  logic [1:0]  wid;
  logic        dir, pend, busy;
  logic [29:0] wad;
  logic [3:0]  be;

  wire [1:0]  lane   = ptr[1:0];
  wire        last   = left == 16'd1;
  wire        fl_hs  = fl_req & fl_ack;
  wire        mem_hs = mem_req & mem_ack;
  wire        go     = reg_wr && reg_addr == 8'h18 && !busy;
  wire [15:0] lim    = reg_wdata[0] ? WR_LIM : RD_LIM;
  wire [15:0] eff    = cnt > lim ? lim : cnt;
  wire        done   = (st == S_MPUT && mem_hs && left == 16'd0) ||
                       (st == S_FPUT && fl_hs && last) ||
                       (go && eff == 16'd0);

  assign busy      = st != S_IDLE;
  assign irq       = cfg[IE_BIT] & pend;
  assign mem_req   = st == S_MPUT || st == S_MGET;
  assign mem_we    = st == S_MPUT;
  assign mem_addr  = st == S_MPUT ? {wad, 2'b00} : {ptr[31:2], 2'b00};
  assign mem_be    = st == S_MPUT ? be : 4'hf;
  assign mem_wdata = buffer;
  assign fl_req    = st == S_FGET || st == S_FPUT;
  assign fl_wr     = dir;
  assign fl_width  = wid;
  assign fl_wbyte  = buffer[{~lane, 3'b000} +: 8];

  always_comb begin
    case (reg_addr)
      8'h00:   reg_rdata = cfg;
      8'h18:   reg_rdata = {31'd0, dir};
      8'h1c:   reg_rdata = base;
      8'h20:   reg_rdata = {31'd0, pend};
      8'h24:   reg_rdata = {2'b00, wid, 12'h000, cnt};
      8'h40:   reg_rdata = {28'd0, busy, busy & ~dir, busy & dir, 1'b0};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0; base <= '0; cnt <= '0; wid <= '0; pend <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == 8'h00) cfg <= reg_wdata;
      if (reg_wr && reg_addr == 8'h1c && !busy) base <= reg_wdata;
      if (reg_wr && reg_addr == 8'h24 && !busy) begin
        cnt <= reg_wdata[15:0];
        wid <= reg_wdata[29:28];
      end
      if (done) pend <= 1'b1;
      else if (reg_wr && reg_addr == 8'h20 && reg_wdata[0]) pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dir <= 1'b0; ptr <= '0; left <= '0;
      buffer <= '0; be <= '0; wad <= '0;
    end else begin
      case (st)
        S_IDLE: if (go && eff != 16'd0) begin
          dir  <= reg_wdata[0];
          ptr  <= base;
          left <= eff;
          be   <= 4'h0;
          st   <= reg_wdata[0] ? S_MGET : S_FGET;
        end
        S_FGET: if (fl_hs) begin
          buffer[{~lane, 3'b000} +: 8] <= fl_rbyte;
          be[~lane] <= 1'b1;
          wad  <= ptr[31:2];
          ptr  <= ptr + 32'd1;
          left <= left - 16'd1;
          if (lane == 2'd3 || last) st <= S_MPUT;
        end
        S_MPUT: if (mem_hs) begin
          be <= 4'h0;
          st <= left == 16'd0 ? S_IDLE : S_FGET;
        end
        S_MGET: if (mem_hs) begin
          buffer <= mem_rdata;
          st <= S_FPUT;
        end
        S_FPUT: if (fl_hs) begin
          ptr  <= ptr + 32'd1;
          left <= left - 16'd1;
          if (last) st <= S_IDLE;
          else if (lane == 2'd3) st <= S_MGET;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_dma_engine_chk.sv
module flash_dma_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        pend,
  input logic [31:0] base,
  input logic        reg_wr,
  input logic [7:0]  reg_addr,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        fl_req,
  input logic [7:0]  fl_wbyte,
  input logic        fl_ack
);
  assert_mem_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_be) &&
                            $stable(mem_we) && $stable(mem_wdata));

  assert_fl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req && !fl_ack |=> fl_req && $stable(fl_wbyte));

  assert_one_side_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && fl_req));

  assert_enable_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_be != 4'h0);

  assert_idle_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> !busy);

  assert_base_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == 8'h1c |=> $stable(base));
endmodule

bind flash_dma_engine flash_dma_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .pend(pend), .base(base),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .fl_req(fl_req), .fl_wbyte(fl_wbyte), .fl_ack(fl_ack)
);

// File: tb/flash_dma_engine_test.sv
module flash_dma_engine_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, fl_req, fl_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 0;
  logic [3:0] mem_be;
  logic mem_ack = 0, fl_ack = 0;
  logic [1:0] fl_width;
  logic [7:0] fl_wbyte, fl_rbyte = 0;

  flash_dma_engine uut (.*);

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [7:0] mem [0:4095];
  int tx_base = 0, tx_eff = 0, tx_seed = 0, fidx = 0;
  logic [1:0] tx_wid = 0;

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 7 + s) & 255);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", cyc, 0);
      finish_up();
    end
    if (rst_n) chk(!(mem_req && fl_req), "R11", {mem_req, fl_req}, 0);
    mem_ack = 0;
    fl_ack = 0;
    if (mem_req && (cyc % 3 != 1)) begin
      mem_ack = 1;
      if (mem_we) begin
        for (int k = 0; k < 4; k++) begin
          if (mem_be[3-k]) begin
            int a, off;
            logic [7:0] b;
            a = int'(mem_addr) + k;
            off = a - tx_base;
            b = mem_wdata[31-8*k -: 8];
            chk(off >= 0 && off < tx_eff && b == pat(off, tx_seed), "R3", b, pat(off, tx_seed));
            mem[a & 4095] = b;
          end
        end
      end else begin
        for (int k = 0; k < 4; k++)
          mem_rdata[31-8*k -: 8] = mem[(int'(mem_addr) + k) & 4095];
      end
    end
    if (fl_req && (cyc % 4 != 2)) begin
      fl_ack = 1;
      chk(fl_width == tx_wid, "R11", fl_width, tx_wid);
      if (!fl_wr) fl_rbyte = pat(fidx, tx_seed);
      else chk(fl_wbyte == mem[(tx_base + fidx) & 4095], "R4", fl_wbyte, mem[(tx_base + fidx) & 4095]);
      fidx++;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      rd(8'h40, s);
      if (s[3] == 0) return;
    end
  endtask

  task automatic start(bit d, int a, int len, logic [1:0] w, int seed);
    int lim;
    lim = d ? 520 : 2080;
    tx_base = a; tx_seed = seed; tx_wid = w; fidx = 0;
    tx_eff = len > lim ? lim : len;
    wr(8'h1c, a);
    wr(8'h24, {2'b00, w, 12'h000, 16'(len)});
    wr(8'h18, {31'd0, d});
  endtask

  initial begin
    logic [31:0] v;
    logic [7:0] n0, n1;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5a;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(8'h40, v); chk(v == 0, "R1 status", v, 0);
    rd(8'h20, v); chk(v == 0, "R1 pending", v, 0);
    chk({irq, mem_req, fl_req} == 0, "R1 outputs", {irq, mem_req, fl_req}, 0);

    // R2 readback
    wr(8'h00, 32'h0010_0000);
    rd(8'h00, v); chk(v == 32'h0010_0000, "R2 config", v, 32'h0010_0000);

    // R3 read run from odd offset, lane code 2
    n0 = mem[12'h100]; n1 = mem[12'h10b];
    start(0, 32'h101, 10, 2'd2, 3);
    rd(8'h40, v); chk(v[3:0] == 4'hc, "R7 read busy", v, 32'hc);
    rd(8'h1c, v); chk(v == 32'h101, "R2 address", v, 32'h101);
    rd(8'h24, v); chk(v == 32'h2000_000a, "R2 length", v, 32'h2000_000a);
    wait_idle();
    chk(fidx == 10, "R3 byte total", fidx, 10);
    chk(mem[12'h100] == n0 && mem[12'h10b] == n1, "R3 neighbours", {mem[12'h100], mem[12'h10b]}, {n0, n1});
    rd(8'h20, v); chk(v == 1, "R5 pending", v, 1);
    chk(irq == 1, "R6 irq enabled", irq, 1);
    wr(8'h00, 0);
    chk(irq == 0, "R6 irq masked", irq, 0);
    wr(8'h20, 0);
    rd(8'h20, v); chk(v == 1, "R5 write 0 keeps", v, 1);
    wr(8'h20, 1);
    rd(8'h20, v); chk(v == 0, "R5 write 1 clears", v, 0);

    // R4 write run from offset 3
    start(1, 32'h203, 9, 2'd1, 0);
    rd(8'h40, v); chk(v[3:0] == 4'ha, "R7 write busy", v, 32'ha);
    wait_idle();
    chk(fidx == 9, "R4 byte total", fidx, 9);
    rd(8'h20, v); chk(v == 1, "R5 pending write", v, 1);
    wr(8'h20, 1);

    // R8 truncation
    start(0, 32'h400, 3000, 2'd0, 11);
    wait_idle();
    chk(fidx == 2080, "R8 read limit", fidx, 2080);
    wr(8'h20, 1);
    start(1, 32'h402, 700, 2'd0, 0);
    wait_idle();
    chk(fidx == 520, "R8 write limit", fidx, 520);
    wr(8'h20, 1);

    // R9 zero length
    start(0, 32'h50, 0, 2'd0, 1);
    chk(!mem_req && !fl_req, "R9 no request", {mem_req, fl_req}, 0);
    rd(8'h20, v); chk(v == 1, "R9 pending", v, 1);
    rd(8'h40, v); chk(v == 0, "R9 idle", v, 0);
    chk(fidx == 0, "R9 no bytes", fidx, 0);
    wr(8'h20, 1);

    // R10 writes ignored while busy
    start(0, 32'h600, 40, 2'd1, 5);
    wr(8'h1c, 32'h700);
    wr(8'h24, 32'h0000_0003);
    wr(8'h18, 32'h1);
    wr(8'h00, 32'h0010_0000);
    rd(8'h1c, v); chk(v == 32'h600, "R10 address locked", v, 32'h600);
    rd(8'h24, v); chk(v == 32'h1000_0028, "R10 length locked", v, 32'h1000_0028);
    rd(8'h00, v); chk(v == 32'h0010_0000, "R10 config writable", v, 32'h0010_0000);
    wait_idle();
    chk(fidx == 40, "R10 run unchanged", fidx, 40);
    rd(8'h18, v); chk(v == 0, "R10 direction kept", v, 0);
    chk(irq == 1, "R6 irq after run", irq, 1);

    finish_up();
  end
endmodule